// File: doc/BRIEF.md
# Half-Word Host to Word Register Bridge

This block sits between a 16-bit host bus and an internal port that reads and writes whole 32-bit words. Each host access moves one half-word. Address bit 1 selects the half: 0 is the low half, bits 15:0, and 1 is the high half, bits 31:16. Address bits 2 and up give the word. The host may access either half first. The bridge pairs the two halves so that each complete word causes exactly one internal write, or exactly one internal fetch. This lets a FIFO behind the port see one push or one pop per word.

Writes are gathered. The first half is held. The opposite half of the same word then triggers one 32-bit write. Reads fetch the whole word on the first half and latch it. The second half is served from the latch. An access that repeats the pending half breaks the pair. It is flagged on a one-cycle error output and the pairing restarts.

Top module: `hb16to32_bridge`

## Requirements
- R1: When a host write hits the opposite half of the same word as a pending write half, `reg_wr_en` is high for exactly one cycle, starting the cycle after that second write. In that cycle `reg_wr_addr` equals host_addr[ADDR_W-1:2] and `reg_wr_data` carries the low-half data (address bit 1 = 0) in bits 15:0 and the high-half data in bits 31:16, in whichever order they arrived.
- R2: A single write half on its own never produces an internal write.
- R3: A write to the same half as the pending write half of the same word is discarded. No internal write occurs, `host_err` pulses for one cycle after it, and the next write is treated as a first half.
- R4: A read that starts a pair drives `reg_rd_en` high in the same cycle as `host_rd_en`, with `reg_rd_addr` equal to the word address. In the next cycle `host_rvalid` is 1 and `host_rdata` holds the selected half of `reg_rd_data`.
- R5: The second read half of a pair causes no fetch. It returns the other half of the word latched at the first half, even if the internal word has changed since then.
- R6: A read of the same half as the pending read half causes no fetch. In the next cycle `host_rvalid` = 0, `host_rdata` = 0 and `host_err` = 1. The next read starts a new pair and fetches again.
- R7: An access to a different word address than the pending half drops the pending half without error. The new access is treated as a first half.
- R8: Synchronous active-low reset clears all pairing state and drives `host_rvalid`, `host_rdata`, `host_err` and `reg_wr_en` to 0. The first access after reset is always a first half.
- R9: If `host_wr_en` and `host_rd_en` are both high, only the write is serviced. An access of the other kind (read versus write) drops a pending half and starts a new pair.
- R10: Any number of idle cycles may separate the two halves of a pair without breaking it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W-1 | Host byte address bits ADDR_W-1..1; bit 1 selects the half |
| host_wr_en | input | 1 | One-cycle host half-word write strobe |
| host_wdata | input | 16 | Host write data |
| host_rd_en | input | 1 | One-cycle host half-word read strobe |
| host_rdata | output | 16 | Read half-word, zero unless host_rvalid |
| host_rvalid | output | 1 | host_rdata is valid |
| host_err | output | 1 | One-cycle pulse on a discarded write or an invalid read |
| reg_wr_en | output | 1 | Internal 32-bit write strobe |
| reg_wr_addr | output | ADDR_W-2 | Internal write word address |
| reg_wr_data | output | 32 | Internal write data |
| reg_rd_en | output | 1 | Internal fetch strobe (FIFO pop) |
| reg_rd_addr | output | ADDR_W-2 | Internal fetch word address |
| reg_rd_data | input | 32 | Internal word returned in the same cycle as reg_rd_en |

## Verification
The fetch strobe is combinational and is counted at the clock edge where the host read is sampled. Read data, the error pulse and the internal write all appear one cycle after that edge. The bench drives each access at a falling edge and samples at the next falling edge. The internal write and read data are checked there, together with the number of fetches counted at the rising edge in between. One more idle cycle follows, in which `host_err` and `reg_wr_en` must be back to 0. This also lets the write land in the bench's word store before the next access is predicted.

// File: rtl/hb16_pkg.sv
`timescale 1ns/1ps
// Shared widths and access classification types for the half-word bridge.
// Assumes a 16-bit host half and a 32-bit internal word.
package hb16_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WR   = 2'd1,
        ACC_RD   = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        CLS_IDLE   = 2'd0,
        CLS_FIRST  = 2'd1,
        CLS_SECOND = 2'd2,
        CLS_REPEAT = 2'd3
    } acc_class_e;
endpackage

// File: rtl/hb16_pair_track.sv
`timescale 1ns/1ps
// Pairing tracker: remembers the pending first half (kind, half, word) and
// classifies each incoming access as first, second or repeated half.
// Assumes at most one access kind per cycle (priority resolved upstream).
module hb16_pair_track
    import hb16_pkg::*;
#(
    parameter int WADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  acc_kind_e          acc_kind,
    input  logic               acc_half,
    input  logic [WADDR_W-1:0] acc_waddr,
    output acc_class_e         acc_class
);
    logic               pend_valid;
    acc_kind_e          pend_kind;
    logic               pend_half;
    logic [WADDR_W-1:0] pend_waddr;
    logic               same_pair;

    // Classify the current access against the pending half.
    always_comb begin
        same_pair = pend_valid && (pend_kind == acc_kind) && (pend_waddr == acc_waddr);
        if (acc_kind == ACC_NONE) begin
            acc_class = CLS_IDLE;
        end else if (!same_pair) begin
            acc_class = CLS_FIRST;
        end else if (acc_half != pend_half) begin
            acc_class = CLS_SECOND;
        end else begin
            acc_class = CLS_REPEAT;
        end
    end

    // Update the pending-half record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_kind  <= ACC_NONE;
            pend_half  <= 1'b0;
            pend_waddr <= '0;
        end else begin
            case (acc_class)
                CLS_FIRST: begin
                    pend_valid <= 1'b1;
                    pend_kind  <= acc_kind;
                    pend_half  <= acc_half;
                    pend_waddr <= acc_waddr;
                end
                CLS_SECOND, CLS_REPEAT: pend_valid <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_PAIR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == CLS_SECOND || acc_class == CLS_REPEAT) |=> (acc_class != CLS_SECOND && acc_class != CLS_REPEAT)); // R3
endmodule

// File: rtl/hb16_wr_gather.sv
`timescale 1ns/1ps
// Write gatherer: holds the first write half and, on the opposite half,
// issues one registered 32-bit internal write with halves placed by address.
// Assumes classification from hb16_pair_track.
module hb16_wr_gather
    import hb16_pkg::*;
#(
    parameter int WADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  acc_class_e         acc_class,
    input  logic               is_wr,
    input  logic               acc_half,
    input  logic [WADDR_W-1:0] acc_waddr,
    input  logic [HALF_W-1:0]  wdata,
    output logic               wr_en,
    output logic [WADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0]  wr_data
);
    logic [HALF_W-1:0] hold_q;

    // Keep the first half's data until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (is_wr && acc_class == CLS_FIRST) begin
            hold_q <= wdata;
        end
    end

    // Issue the combined word when the partner half completes the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= is_wr && (acc_class == CLS_SECOND);
            if (is_wr && acc_class == CLS_SECOND) begin
                wr_addr <= acc_waddr;
                wr_data <= acc_half ? {wdata, hold_q} : {hold_q, wdata};
            end
        end
    end

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R1
endmodule

// File: rtl/hb16_rd_split.sv
`timescale 1ns/1ps
// Read splitter: latches the fetched word on the first read half and serves
// the second half from the latch; an invalid repeat returns zero data.
// Assumes the internal word is valid in the cycle of the fetch strobe.
module hb16_rd_split
    import hb16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  acc_class_e        acc_class,
    input  logic              is_rd,
    input  logic              acc_half,
    input  logic [WORD_W-1:0] fetch_data,
    output logic              rvalid,
    output logic [HALF_W-1:0] rdata
);
    logic [WORD_W-1:0] latch_q;
    logic [WORD_W-1:0] src_word;

    // Pick the word that serves this read: fresh fetch or latched copy.
    always_comb begin
        src_word = (acc_class == CLS_FIRST) ? fetch_data : latch_q;
    end

    // Capture the fetched word once per pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (is_rd && acc_class == CLS_FIRST) begin
            latch_q <= fetch_data;
        end
    end

    // Register the returned half; zero whenever not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (is_rd && (acc_class == CLS_FIRST || acc_class == CLS_SECOND)) begin
            rvalid <= 1'b1;
            rdata  <= acc_half ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];
        end else begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end
    end

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0)); // R6
endmodule

// File: rtl/hb16to32_bridge.sv
`timescale 1ns/1ps
// Top: bridges 16-bit host half-word accesses to a 32-bit internal port.
// Address bit 1 selects the half, bits ADDR_W-1..2 the word. Writes win
// over simultaneous reads. Assumes one-cycle host strobes.
module hb16to32_bridge
    import hb16_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:1]   host_addr,
    input  logic                host_wr_en,
    input  logic [15:0]         host_wdata,
    input  logic                host_rd_en,
    output logic [15:0]         host_rdata,
    output logic                host_rvalid,
    output logic                host_err,
    output logic                reg_wr_en,
    output logic [ADDR_W-3:0]   reg_wr_addr,
    output logic [31:0]         reg_wr_data,
    output logic                reg_rd_en,
    output logic [ADDR_W-3:0]   reg_rd_addr,
    input  logic [31:0]         reg_rd_data
);
    localparam int WADDR_W = ADDR_W - 2;

    acc_kind_e          acc_kind;
    acc_class_e         acc_class;
    logic               is_wr;
    logic               is_rd;
    logic               acc_half;
    logic [WADDR_W-1:0] acc_waddr;

    // Decode the access kind (write priority) and address fields.
    always_comb begin
        is_wr     = host_wr_en;
        is_rd     = host_rd_en && !host_wr_en;
        acc_half  = host_addr[1];
        acc_waddr = host_addr[ADDR_W-1:2];
        if (is_wr)      acc_kind = ACC_WR;
        else if (is_rd) acc_kind = ACC_RD;
        else            acc_kind = ACC_NONE;
    end

    hb16_pair_track #(.WADDR_W(WADDR_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_kind  (acc_kind),
        .acc_half  (acc_half),
        .acc_waddr (acc_waddr),
        .acc_class (acc_class)
    );

    hb16_wr_gather #(.WADDR_W(WADDR_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_class (acc_class),
        .is_wr     (is_wr),
        .acc_half  (acc_half),
        .acc_waddr (acc_waddr),
        .wdata     (host_wdata),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data)
    );

    hb16_rd_split u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_class  (acc_class),
        .is_rd      (is_rd),
        .acc_half   (acc_half),
        .fetch_data (reg_rd_data),
        .rvalid     (host_rvalid),
        .rdata      (host_rdata)
    );

    // Fetch the internal word only on a read that opens a pair.
    always_comb begin
        reg_rd_en   = is_rd && (acc_class == CLS_FIRST);
        reg_rd_addr = acc_waddr;
    end

    // Flag a repeated half for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) host_err <= 1'b0;
        else        host_err <= (acc_class == CLS_REPEAT);
    end

    AST_WR_FOLLOWS_HOST_WR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(host_wr_en)); // R1
    AST_NO_WR_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> !reg_wr_en); // R3
    AST_FETCH_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (host_rd_en && !host_wr_en)); // R9
    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> ($past(host_rd_en) && !$past(host_wr_en))); // R4
    AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> !host_rvalid); // R6
endmodule

// File: tb/hb16to32_bridge_tb.sv
`timescale 1ns/1ps
module hb16to32_bridge_tb;
    localparam int ADDR_W  = 8;
    localparam int WADDR_W = ADDR_W - 2;
    localparam int NWORDS  = 1 << WADDR_W;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [ADDR_W-1:1]   host_addr;
    logic                host_wr_en;
    logic [15:0]         host_wdata;
    logic                host_rd_en;
    logic [15:0]         host_rdata;
    logic                host_rvalid;
    logic                host_err;
    logic                reg_wr_en;
    logic [WADDR_W-1:0]  reg_wr_addr;
    logic [31:0]         reg_wr_data;
    logic                reg_rd_en;
    logic [WADDR_W-1:0]  reg_rd_addr;
    logic [31:0]         reg_rd_data;

    logic [31:0] mem [NWORDS];
    int fetch_cnt = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state
    bit          m_pv;
    bit          m_pk_rd;
    bit          m_ph;
    int          m_pa;
    logic [15:0] m_hold;
    logic [31:0] m_latch;

    always #2.5 clk = ~clk;

    hb16to32_bridge #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
        .host_wdata(host_wdata), .host_rd_en(host_rd_en), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .host_err(host_err), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    assign reg_rd_data = mem[reg_rd_addr];

    always @(posedge clk) begin
        if (reg_rd_en) fetch_cnt <= fetch_cnt + 1;
        if (reg_wr_en) mem[reg_wr_addr] <= reg_wr_data;
    end

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; host_wr_en = 0; host_rd_en = 0; host_addr = '0; host_wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_pv = 0;
    endtask

    // One host access, predicted by the model and checked at the ports.
    task automatic access(input string tag, input bit w, input bit r,
                          input logic [ADDR_W-1:1] a, input logic [15:0] d);
        bit          e_wr = 0, e_rv = 0, e_err = 0;
        int          e_fetch = 0;
        logic [31:0] e_wdata = '0;
        logic [15:0] e_rdata = '0;
        bit          half = a[1];
        int          wa = int'(a[ADDR_W-1:2]);
        bit          krd = !w;
        int          f0;
        if (w || r) begin
            if (!(m_pv && m_pk_rd == krd && m_pa == wa)) begin
                m_pv = 1; m_pk_rd = krd; m_ph = half; m_pa = wa;
                if (w) m_hold = d;
                else begin
                    e_fetch = 1; m_latch = mem[wa]; e_rv = 1;
                    e_rdata = half ? m_latch[31:16] : m_latch[15:0];
                end
            end else if (half != m_ph) begin
                m_pv = 0;
                if (w) begin
                    e_wr = 1; e_wdata = half ? {d, m_hold} : {m_hold, d};
                end else begin
                    e_rv = 1; e_rdata = half ? m_latch[31:16] : m_latch[15:0];
                end
            end else begin
                m_pv = 0; e_err = 1;
            end
        end
        f0 = fetch_cnt;
        @(negedge clk);
        host_wr_en = w; host_rd_en = r; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 0; host_rd_en = 0;
        check(tag, "fetch count", fetch_cnt - f0, e_fetch);
        check(tag, "rvalid", host_rvalid, e_rv);
        check(tag, "rdata", host_rdata, e_rdata);
        check(tag, "err", host_err, e_err);
        check(tag, "wr_en", reg_wr_en, e_wr);
        if (e_wr) begin
            check(tag, "wr_addr", reg_wr_addr, wa);
            check(tag, "wr_data", reg_wr_data, e_wdata);
        end
        @(negedge clk);
        check(tag, "err pulse ends", host_err, 0);
        check(tag, "wr pulse ends", reg_wr_en, 0);
    endtask

    function automatic logic [ADDR_W-1:1] ad(input int word, input bit half);
        logic [ADDR_W-1:1] x;
        x = '0;
        x[ADDR_W-1:2] = word[WADDR_W-1:0];
        x[1] = half;
        return x;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NWORDS; i++) mem[i] = 32'hA000_0000 + i * 32'h0101_0011;
        host_wr_en = 0; host_rd_en = 0; host_addr = '0; host_wdata = '0; rst_n = 0;
        do_reset();
        // R8: reset state
        check("R8", "rvalid", host_rvalid, 0);
        check("R8", "rdata", host_rdata, 0);
        check("R8", "err", host_err, 0);
        check("R8", "wr_en", reg_wr_en, 0);
        // R1: both orders
        access("R1", 1, 0, ad(3, 0), 16'h1111);
        access("R1", 1, 0, ad(3, 1), 16'h2222);
        access("R1", 1, 0, ad(4, 1), 16'h3333);
        access("R1", 1, 0, ad(4, 0), 16'h4444);
        // R2 and R10: lone half, long gap, then partner
        access("R2", 1, 0, ad(5, 0), 16'h5555);
        repeat (20) @(negedge clk);
        check("R2", "no write on lone half", reg_wr_en, 0);
        access("R10", 1, 0, ad(5, 1), 16'h6666);
        // R3: repeated write half
        access("R3", 1, 0, ad(6, 0), 16'h7777);
        access("R3", 1, 0, ad(6, 0), 16'h8888);
        access("R3", 1, 0, ad(6, 1), 16'h9999);
        access("R3", 1, 0, ad(6, 0), 16'hAAAA);
        // R4/R5: read pair, internal word changes between halves
        access("R4", 0, 1, ad(3, 0), 16'h0);
        mem[3] = 32'hDEAD_BEEF;
        access("R5", 0, 1, ad(3, 1), 16'h0);
        access("R4", 0, 1, ad(4, 1), 16'h0);
        access("R5", 0, 1, ad(4, 0), 16'h0);
        // R6: repeated read half then fresh pair
        access("R6", 0, 1, ad(7, 1), 16'h0);
        access("R6", 0, 1, ad(7, 1), 16'h0);
        access("R6", 0, 1, ad(7, 0), 16'h0);
        access("R6", 0, 1, ad(7, 1), 16'h0);
        // R7: word change between halves
        access("R7", 1, 0, ad(1, 0), 16'hB0B0);
        access("R7", 1, 0, ad(2, 1), 16'hC1C1);
        access("R7", 1, 0, ad(2, 0), 16'hD2D2);
        access("R7", 0, 1, ad(1, 0), 16'h0);
        access("R7", 0, 1, ad(2, 1), 16'h0);
        // R9: simultaneous write and read, and kind change
        access("R9", 1, 1, ad(8, 0), 16'hE3E3);
        access("R9", 1, 1, ad(8, 1), 16'hF4F4);
        access("R9", 0, 1, ad(9, 0), 16'h0);
        access("R9", 1, 0, ad(9, 1), 16'h1234);
        access("R9", 0, 1, ad(9, 1), 16'h0);
        // R8: reset mid-pair
        access("R8", 1, 0, ad(10, 0), 16'h5678);
        do_reset();
        access("R8", 1, 0, ad(10, 1), 16'h9ABC);
        // Random mix over two words to provoke all classes
        for (int i = 0; i < 600; i++) begin
            int k;
            k = int'($urandom_range(0, 4));
            access("RND", k == 0 || k == 4, k >= 1, ad(int'($urandom_range(0, 1)), 1'($urandom_range(0, 1))),
                   16'($urandom));
            if ($urandom_range(0, 7) == 0) repeat (int'($urandom_range(1, 4))) @(negedge clk);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule